// File: doc/BRIEF.md
# Software-Managed Page Translator

This block sits between a processor bus and a memory port and turns 32-bit virtual addresses into physical ones. Addresses are cut into 4 KB pages. A 20-bit page number is looked up in a small, fully associative table of eight slots, and the 12-bit offset passes through unchanged. Each slot holds a virtual page number, a physical page number, a valid bit and two control flags. The *loaded* flag says whether the page contents are present in memory. The *pinned* flag shields the slot from being overwritten.

A request whose page matches a slot with the loaded flag set is forwarded to memory in the same cycle, with the translated address. All other requests raise an interrupt and stall the processor. This covers an unmatched page and a matched page whose contents are not loaded yet. The faulting address and a cause code are recorded. Software then repairs the table through a small register port and writes a retry bit. After that the stalled request is looked up again.

The block has no page-walk hardware and no loader. Both are left to the interrupt handler. The register port also reports the lowest free slot, so the handler can find a place for a new mapping without scanning.

Top module: `tlb_xlate`

## Requirements
- R1: After the synchronous active-high reset, `irq` is 0, every slot is invalid, and register 5 reads 0 (free slot 0, full flag in bit 31 clear).
- R2: While `cpu_req` is 1 and no fault is pending, a match on a slot whose loaded flag is set drives `mem_req`=1, `cpu_ready`=1 and `mem_addr` = {slot physical page, `cpu_addr`[11:0]} in the same cycle. `mem_we` follows `cpu_we`.
- R3: A request that matches no valid slot sets `irq` from the next cycle. Register 3 then reads the faulting address, and register 4 reads cause 2'b01 in bits 1:0, with bit 31 set while the fault is pending.
- R4: A request that matches a slot whose loaded flag is 0 is not forwarded. It sets `irq` with cause 2'b10.
- R5: While a fault is pending, `cpu_ready` and `mem_req` stay 0 and the recorded address and cause do not change.
- R6: Writing bit 0 = 1 to register 3 while a fault is pending drops `irq` on the next cycle. The held request is then looked up again and, if it now qualifies, forwarded.
- R7: When several valid slots match, the lowest-numbered one supplies the physical page.
- R8: A write to register 2 copies the staged words into a slot. The staged words are register 0 (virtual page in 31:12) and register 1 (physical page in 31:12, loaded flag in bit 0, pinned flag in bit 1). Register 2 carries the slot index in bits 7:0, a force bit in bit 8 and the new valid bit in bit 9. A lookup in the same cycle as the write still sees the old table.
- R9: A write to a slot that is both valid and pinned has no effect unless the force bit is 1 in that write.
- R10: Register 5 reads the lowest-numbered invalid slot in its low bits. When all slots are valid, bit 31 of register 5 is 1.
- R11: Rewriting a slot with its loaded flag set to 1 turns a not-loaded fault into a forwarded access after retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 32 | Virtual address |
| cpu_ready | output | 1 | Access forwarded this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Physical address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Fault interrupt request |

## Verification
Two things can land in the same clock cycle: a processor lookup and a software commit that installs the very page being looked up. The bench provokes this by presenting the request and the register 2 write at the same falling edge. The request must still fault with cause "miss", because the table change only becomes visible after the edge. Once the retry bit is written, the same held request must be forwarded with the newly installed physical page.

A second overlap is the retry write that ends a fault. The lookup in that write's cycle must stay stalled, and forwarding must appear only in the following cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int ADDR_W    = 32;
  parameter int PAGE_BITS = 12;
  localparam int PN_W     = ADDR_W - PAGE_BITS;

  // flag positions inside the staged physical word
  localparam int FLG_LOADED = 0;
  localparam int FLG_PINNED = 1;

  // commit word fields
  localparam int CMT_FORCE = 8;
  localparam int CMT_VALID = 9;

  // register select values
  localparam logic [2:0] RA_VSTAGE = 3'd0;
  localparam logic [2:0] RA_PSTAGE = 3'd1;
  localparam logic [2:0] RA_COMMIT = 3'd2;
  localparam logic [2:0] RA_FAULT  = 3'd3;
  localparam logic [2:0] RA_STATUS = 3'd4;
  localparam logic [2:0] RA_FREE   = 3'd5;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_MISS   = 2'b01,
    CAUSE_ABSENT = 2'b10
  } cause_e;

  function automatic logic [PN_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_BITS-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PN_W-1:0] pn,
                                                  input logic [PAGE_BITS-1:0] off);
    return {pn, off};
  endfunction
endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [PN_W-1:0]       wr_vpn,
  input  logic [PN_W-1:0]       wr_ppn,
  input  logic                  wr_loaded,
  input  logic                  wr_pinned,
  input  logic                  wr_valid,
  input  logic                  wr_force,
  output logic [N-1:0]          valid,
  output logic [N-1:0]          loaded,
  output logic [N-1:0]          pinned,
  output logic [N-1:0][PN_W-1:0] vpn,
  output logic [N-1:0][PN_W-1:0] ppn,
  output logic                  blocked
);
  logic apply;

  assign blocked = wr_en && valid[wr_idx] && pinned[wr_idx] && !wr_force;
  assign apply   = wr_en && !blocked;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        valid[g]  <= 1'b0;
        loaded[g] <= 1'b0;
        pinned[g] <= 1'b0;
        vpn[g]    <= '0;
        ppn[g]    <= '0;
      end else if (apply && wr_idx == IW'(g)) begin
        valid[g]  <= wr_valid;
        loaded[g] <= wr_loaded;
        pinned[g] <= wr_pinned;
        vpn[g]    <= wr_vpn;
        ppn[g]    <= wr_ppn;
      end
    end
  end
endmodule

// File: rtl/tlb_fault.sv
module tlb_fault
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic [ADDR_W-1:0] set_addr,
  input  cause_e            set_cause,
  input  logic              clr,
  output logic              pend,
  output logic [ADDR_W-1:0] addr,
  output cause_e            cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      addr  <= '0;
      cause <= CAUSE_NONE;
    end else if (set) begin
      pend  <= 1'b1;
      addr  <= set_addr;
      cause <= set_cause;
    end else if (clr) begin
      pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0] stage_v, stage_p;
  logic [ENTRIES-1:0] s_valid, s_loaded, s_pinned, match_vec;
  logic [ENTRIES-1:0][PN_W-1:0] s_vpn, s_ppn;
  logic        hit, free_found;
  logic [IW-1:0] hit_idx, free_idx;
  logic        flt_pend;
  logic [ADDR_W-1:0] flt_addr;
  cause_e      flt_cause;

  // named events for the checker
  logic ev_commit, ev_commit_blocked, ev_fwd, ev_fault_set, ev_fault_clr;
  cause_e look_cause;

  assign ev_commit    = reg_we && reg_addr == RA_COMMIT;
  assign ev_fault_clr = reg_we && reg_addr == RA_FAULT && reg_wdata[0] && flt_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= '0;
      stage_p <= '0;
    end else if (reg_we) begin
      if (reg_addr == RA_VSTAGE) stage_v <= reg_wdata;
      if (reg_addr == RA_PSTAGE) stage_p <= reg_wdata;
    end
  end

  tlb_slot_array #(.N(ENTRIES)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ev_commit),
    .wr_idx    (reg_wdata[IW-1:0]),
    .wr_vpn    (page_of(stage_v)),
    .wr_ppn    (page_of(stage_p)),
    .wr_loaded (stage_p[FLG_LOADED]),
    .wr_pinned (stage_p[FLG_PINNED]),
    .wr_valid  (reg_wdata[CMT_VALID]),
    .wr_force  (reg_wdata[CMT_FORCE]),
    .valid     (s_valid),
    .loaded    (s_loaded),
    .pinned    (s_pinned),
    .vpn       (s_vpn),
    .ppn       (s_ppn),
    .blocked   (ev_commit_blocked)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = s_valid[g] && (s_vpn[g] == page_of(cpu_addr));
  end

  tlb_first_one #(.N(ENTRIES)) u_pick (
    .vec   (match_vec),
    .found (hit),
    .idx   (hit_idx)
  );

  tlb_first_one #(.N(ENTRIES)) u_free (
    .vec   (~s_valid),
    .found (free_found),
    .idx   (free_idx)
  );

  assign ev_fwd       = cpu_req && !flt_pend && hit && s_loaded[hit_idx];
  assign look_cause   = hit ? CAUSE_ABSENT : CAUSE_MISS;
  assign ev_fault_set = cpu_req && !flt_pend && !(hit && s_loaded[hit_idx]);

  tlb_fault u_fault (
    .clk       (clk),
    .rst       (rst),
    .set       (ev_fault_set),
    .set_addr  (cpu_addr),
    .set_cause (look_cause),
    .clr       (ev_fault_clr),
    .pend      (flt_pend),
    .addr      (flt_addr),
    .cause     (flt_cause)
  );

  assign mem_req   = ev_fwd;
  assign cpu_ready = ev_fwd;
  assign mem_we    = cpu_we;
  assign mem_addr  = join_addr(s_ppn[hit_idx], offset_of(cpu_addr));
  assign irq       = flt_pend;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_VSTAGE: reg_rdata = stage_v;
      RA_PSTAGE: reg_rdata = stage_p;
      RA_FAULT:  reg_rdata = flt_addr;
      RA_STATUS: reg_rdata = {flt_pend, 29'd0, flt_cause};
      RA_FREE:   reg_rdata = {!free_found, 31'(free_idx)};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cpu_req,
  input logic [31:0] cpu_addr,
  input logic        cpu_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        irq,
  input logic [31:0] flt_addr,
  input logic [1:0]  flt_cause,
  input logic        ev_fault_set,
  input logic        ev_fault_clr
);
  p_fwd_shape_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (cpu_ready && cpu_req && mem_addr[11:0] == cpu_addr[11:0]));

  p_fault_latch_r3: assert property (@(posedge clk) disable iff (rst)
    ev_fault_set |=> (irq && flt_addr == $past(cpu_addr)));

  p_cause_code_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flt_cause == 2'b01 || flt_cause == 2'b10));

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!mem_req && !cpu_ready));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq && !ev_fault_clr) |=> (irq && $stable(flt_addr) && $stable(flt_cause)));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ev_fault_clr |=> !irq);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_req      (cpu_req),
  .cpu_addr     (cpu_addr),
  .cpu_ready    (cpu_ready),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .irq          (irq),
  .flt_addr     (flt_addr),
  .flt_cause    (flt_cause),
  .ev_fault_set (ev_fault_set),
  .ev_fault_clr (ev_fault_clr)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_ready, mem_req, mem_we, irq;
  logic [31:0] mem_addr, reg_rdata;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stage(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic k, input logic pin);
    reg_write(3'd0, {vpn, 12'h000});
    reg_write(3'd1, {ppn, 10'd0, pin, k});
  endtask

  function automatic logic [31:0] commit_word(input int idx, input logic force_b,
                                              input logic valid_b);
    return {22'd0, valid_b, force_b, 8'(idx)};
  endfunction

  task automatic install(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic k, input logic pin, input logic force_b,
                         input logic valid_b);
    stage(vpn, ppn, k, pin);
    reg_write(3'd2, commit_word(idx, force_b, valid_b));
  endtask

  // forwarded lookup expected in the cycle the request is presented
  task automatic probe_hit(input string req, input logic [31:0] va, input logic [19:0] ppn);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = va; cpu_we = va[2];
    #1;
    chk(req, {29'd0, mem_req, cpu_ready, mem_we}, {29'd0, 1'b1, 1'b1, va[2]});
    chk(req, mem_addr, {ppn, va[11:0]});
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    reg_read(3'd5, d);
    chk("R1 free", d, 32'd0);
    reg_read(3'd4, d);
    chk("R1 status", d, 32'd0);
  endtask

  task automatic t_miss;
    logic [31:0] d;
    logic [31:0] va = 32'h1000_0008;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = va;
    #1;
    chk("R3 no fwd", {30'd0, mem_req, cpu_ready}, 32'd0);
    @(negedge clk);
    chk("R3 irq", {31'd0, irq}, 32'd1);
    reg_read(3'd3, d);
    chk("R3 addr", d, va);
    reg_read(3'd4, d);
    chk("R3 cause", d, 32'h8000_0001);
    install(0, 20'h10000, 20'h00ABC, 1'b1, 1'b0, 1'b0, 1'b1);
    #1;
    chk("R5 stalled", {30'd0, mem_req, cpu_ready}, 32'd0);
    reg_read(3'd3, d);
    chk("R5 addr held", d, va);
    // retry write cycle: still stalled
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd1;
    #1;
    chk("R6 stall in clear cycle", {30'd0, mem_req, cpu_ready}, 32'd0);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    chk("R6 irq low", {31'd0, irq}, 32'd0);
    chk("R6 fwd", {31'd0, mem_req}, 32'd1);
    chk("R2 addr", mem_addr, 32'h00AB_C008);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic t_absent;
    logic [31:0] d;
    install(1, 20'h20000, 20'h0BEEF, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h2000_0FFC;
    #1;
    chk("R4 no fwd", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    reg_read(3'd4, d);
    chk("R4 cause", d, 32'h8000_0002);
    install(1, 20'h20000, 20'h0BEEF, 1'b1, 1'b0, 1'b0, 1'b1);
    reg_write(3'd3, 32'd1);
    #1;
    chk("R11 fwd after load", {31'd0, mem_req}, 32'd1);
    chk("R11 addr", mem_addr, 32'h0BEE_FFFC);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic t_priority;
    install(2, 20'h30000, 20'h22222, 1'b1, 1'b0, 1'b0, 1'b1);
    install(5, 20'h30000, 20'h55555, 1'b1, 1'b0, 1'b0, 1'b1);
    probe_hit("R7 lowest wins", 32'h3000_0345, 20'h22222);
    install(2, 20'h30000, 20'h22222, 1'b1, 1'b0, 1'b0, 1'b0);
    probe_hit("R7 next match", 32'h3000_0345, 20'h55555);
  endtask

  task automatic t_pinned;
    install(3, 20'h40000, 20'h33333, 1'b1, 1'b1, 1'b0, 1'b1);
    install(3, 20'h40000, 20'h44444, 1'b1, 1'b0, 1'b0, 1'b1);
    probe_hit("R9 protected", 32'h4000_0010, 20'h33333);
    install(3, 20'h40000, 20'h44444, 1'b1, 1'b0, 1'b1, 1'b1);
    probe_hit("R9 forced", 32'h4000_0010, 20'h44444);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    stage(20'h50000, 20'h77777, 1'b1, 1'b0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h5000_0123;
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = commit_word(6, 1'b0, 1'b1);
    #1;
    chk("R8 old table", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    reg_we = 1'b0;
    reg_read(3'd4, d);
    chk("R8 miss cause", d, 32'h8000_0001);
    reg_write(3'd3, 32'd1);
    #1;
    chk("R8 new entry", mem_addr, 32'h7777_7123);
    chk("R8 fwd", {31'd0, mem_req}, 32'd1);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic t_free;
    logic [31:0] d;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    install(0, 20'h00001, 20'h00001, 1'b1, 1'b0, 1'b0, 1'b1);
    install(1, 20'h00002, 20'h00002, 1'b1, 1'b0, 1'b0, 1'b1);
    reg_read(3'd5, d);
    chk("R10 free=2", d, 32'd2);
    for (int i = 2; i < 8; i++)
      install(i, 20'(i + 1), 20'(i + 1), 1'b1, 1'b0, 1'b0, 1'b1);
    reg_read(3'd5, d);
    chk("R10 full", d, 32'h8000_0000);
    install(4, 20'h00005, 20'h00005, 1'b1, 1'b0, 1'b0, 1'b0);
    reg_read(3'd5, d);
    chk("R10 free=4", d, 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss();
    t_absent();
    t_priority();
    t_pinned();
    t_same_cycle();
    t_free();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all-requirements actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule